// File: doc/BRIEF.md
# Four-Line External Interrupt Controller

This block watches up to four asynchronous interrupt pins and, for each pin, turns a programmed trigger condition into a pending flag and a per-line interrupt request towards a parent controller. A line can trigger on a high level, a low level, a rising edge, a falling edge or on either edge. It has a pending status bit, a clear control and an enable mask. Each pin passes through a two-flop synchroniser before any detection.

Software sees all control and status in one 32-bit word, read and written through a plain synchronous port. The word holds six functions, each in its own field of `FIELD_W` bits. The bit for line n of function f sits at n + f × `FIELD_W`. A build-time parameter sets how clear behaves. In the default build, a clear is a one-shot write that always reads back as zero. In the held build, the clear bit stays set and keeps the line quiet until software writes it back to zero.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the register reads 0 and every `irqOut` is 0, so every line is in falling-edge mode and masked.
- R2: Field index f is 0 trigger-polarity, 1 pending status, 2 clear, 3 enable, 4 any-edge, 5 level-mode. Line n of field f is bit n + f × FIELD_W. The polarity, enable, any-edge and level-mode fields read back the last value written, from the cycle after the write. Bits at or above 6 × FIELD_W read 0.
- R3: With level-mode=1, polarity=1 selects active-high and polarity=0 selects active-low. The status bit follows the synchronised pin, updated at the third rising clock edge after the pin changes.
- R4: With level-mode=0, any-edge=0 and polarity=1, a 0-to-1 pin transition sets the status bit.
- R5: With level-mode=0, any-edge=0 and polarity=0, a 1-to-0 pin transition sets the status bit.
- R6: With level-mode=0 and any-edge=1, both transitions set the status bit, whatever the polarity bit holds.
- R7: In an edge mode, a set status bit stays set after the pin returns, until a clear acts on it.
- R8: `irqOut[n]` is a register that takes status[n] AND enable[n]. It rises at the fourth rising edge after a triggering pin change and is 0 whenever the enable bit was 0 in the previous cycle.
- R9: In the default build (HELD_CLEAR=0), a write with clear bit n at 1 forces status[n] to 0 at that write's clock edge, even if a new trigger arrives at the same edge. The clear field always reads 0.
- R10: In the held build (HELD_CLEAR=1), a written clear bit stays set and reads back 1. While it is set, status for that line stays 0 and no trigger reaches `irqOut`, until a write puts the bit back to 0.
- R11: Writes to the status field have no effect; status changes only through triggers and clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irqPins | input | NUM_LINES | Asynchronous external interrupt pins |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Current register contents |
| irqOut | output | NUM_LINES | Per-line interrupt requests to the parent |

## Verification
A pin change made between clock edges reaches the status field at the third rising edge and reaches `irqOut` at the fourth. A register write shows in readback right after its own edge. The new trigger mode steers detection from the next edge on, while a clear acts at the write's own edge. The bench holds a cycle-accurate reference for both clear builds, advances it on each rising edge and compares the outputs at every falling edge, so each result is checked in exactly the cycle it is due. Directed checks also test one cycle before and on the due cycle of the output path, to pin down the latency.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int MAX_LINES  = 4;
  localparam int NUM_FIELDS = 6;
  // field order is decoded by software: keep these indices
  localparam int FLD_SENSE  = 0;
  localparam int FLD_STATUS = 1;
  localparam int FLD_CLEAR  = 2;
  localparam int FLD_MASK   = 3;
  localparam int FLD_BOTH   = 4;
  localparam int FLD_LEVEL  = 5;

  typedef enum logic [2:0] {
    TRIG_FALL,
    TRIG_RISE,
    TRIG_ANY,
    TRIG_LVL_LO,
    TRIG_LVL_HI
  } trig_mode_t;

  // strobes from the register control to the per-line datapath
  typedef struct packed {
    trig_mode_t [MAX_LINES-1:0] mode;
    logic       [MAX_LINES-1:0] clrNow;
  } line_ctl_t;
endpackage

// File: rtl/ext_irq_ctrl_regs.sv
module ext_irq_ctrl_regs
  import ext_irq_pkg::*;
#(
  parameter int NUM_LINES  = 4,
  parameter int FIELD_W    = 4,
  parameter bit HELD_CLEAR = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wrEn,
  input  logic [31:0]          wrData,
  output logic [NUM_LINES-1:0] senseQ,
  output logic [NUM_LINES-1:0] maskQ,
  output logic [NUM_LINES-1:0] bothQ,
  output logic [NUM_LINES-1:0] levelQ,
  output logic [NUM_LINES-1:0] clearRd,
  output line_ctl_t            lineCtl
);
  localparam int SENSE_LSB = FLD_SENSE * FIELD_W;
  localparam int CLEAR_LSB = FLD_CLEAR * FIELD_W;
  localparam int MASK_LSB  = FLD_MASK * FIELD_W;
  localparam int BOTH_LSB  = FLD_BOTH * FIELD_W;
  localparam int LEVEL_LSB = FLD_LEVEL * FIELD_W;

  logic [NUM_LINES-1:0] wrSense, wrClr, wrMask, wrBoth, wrLevel, clrNow;
  logic [31:0] unusedWr;

  assign wrSense  = wrData[SENSE_LSB +: NUM_LINES];
  assign wrClr    = wrData[CLEAR_LSB +: NUM_LINES];
  assign wrMask   = wrData[MASK_LSB +: NUM_LINES];
  assign wrBoth   = wrData[BOTH_LSB +: NUM_LINES];
  assign wrLevel  = wrData[LEVEL_LSB +: NUM_LINES];
  assign unusedWr = wrData;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      senseQ <= '0;
      maskQ  <= '0;
      bothQ  <= '0;
      levelQ <= '0;
    end else if (wrEn) begin
      senseQ <= wrSense;
      maskQ  <= wrMask;
      bothQ  <= wrBoth;
      levelQ <= wrLevel;
    end
  end

  generate
    if (HELD_CLEAR) begin : g_heldClr
      logic [NUM_LINES-1:0] clrHeldQ;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    clrHeldQ <= '0;
        else if (wrEn) clrHeldQ <= wrClr;
      end
      assign clearRd = clrHeldQ;
      assign clrNow  = wrEn ? wrClr : clrHeldQ;
    end else begin : g_pulseClr
      assign clearRd = '0;
      assign clrNow  = wrEn ? wrClr : '0;
    end
  endgenerate

  always_comb begin
    lineCtl = '0;
    lineCtl.clrNow[NUM_LINES-1:0] = clrNow;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (levelQ[i])     lineCtl.mode[i] = senseQ[i] ? TRIG_LVL_HI : TRIG_LVL_LO;
      else if (bothQ[i]) lineCtl.mode[i] = TRIG_ANY;
      else if (senseQ[i]) lineCtl.mode[i] = TRIG_RISE;
      else               lineCtl.mode[i] = TRIG_FALL;
    end
  end
endmodule

// File: rtl/ext_irq_ctrl_path.sv
module ext_irq_ctrl_path
  import ext_irq_pkg::*;
#(
  parameter int NUM_LINES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irqPins,
  input  line_ctl_t            lineCtl,
  input  logic [NUM_LINES-1:0] maskQ,
  output logic [NUM_LINES-1:0] statusQ,
  output logic [NUM_LINES-1:0] irqOut
);
  generate
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      // [0] first stage, [1] synchronised, [2] previous synchronised
      logic [2:0] syncQ;
      logic       stQ, outQ, hit, isLevel, nextSt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncQ <= '0;
        else        syncQ <= {syncQ[1:0], irqPins[n]};
      end

      always_comb begin
        isLevel = 1'b0;
        unique case (lineCtl.mode[n])
          TRIG_LVL_HI: begin hit = syncQ[1];  isLevel = 1'b1; end
          TRIG_LVL_LO: begin hit = ~syncQ[1]; isLevel = 1'b1; end
          TRIG_RISE:   hit = syncQ[1] & ~syncQ[2];
          TRIG_FALL:   hit = ~syncQ[1] & syncQ[2];
          TRIG_ANY:    hit = syncQ[1] ^ syncQ[2];
          default:     hit = 1'b0;
        endcase
        if (lineCtl.clrNow[n]) nextSt = 1'b0;
        else if (isLevel)      nextSt = hit;
        else                   nextSt = stQ | hit;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stQ  <= 1'b0;
          outQ <= 1'b0;
        end else begin
          stQ  <= nextSt;
          outQ <= stQ & maskQ[n];
        end
      end

      assign statusQ[n] = stQ;
      assign irqOut[n]  = outQ;
    end
  endgenerate
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NUM_LINES  = 4,
  parameter int FIELD_W    = 4,
  parameter bit HELD_CLEAR = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irqPins,
  input  logic                 wrEn,
  input  logic [31:0]          wrData,
  output logic [31:0]          rdData,
  output logic [NUM_LINES-1:0] irqOut
);
  logic [NUM_LINES-1:0] senseQ, maskQ, bothQ, levelQ, clearRd, statusQ;
  line_ctl_t lineCtl;

  ext_irq_ctrl_regs #(
    .NUM_LINES(NUM_LINES), .FIELD_W(FIELD_W), .HELD_CLEAR(HELD_CLEAR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData),
    .senseQ(senseQ), .maskQ(maskQ), .bothQ(bothQ), .levelQ(levelQ),
    .clearRd(clearRd), .lineCtl(lineCtl)
  );

  ext_irq_ctrl_path #(
    .NUM_LINES(NUM_LINES)
  ) u_path (
    .clk(clk), .rst_n(rst_n), .irqPins(irqPins), .lineCtl(lineCtl),
    .maskQ(maskQ), .statusQ(statusQ), .irqOut(irqOut)
  );

  always_comb begin
    rdData = '0;
    rdData[FLD_SENSE*FIELD_W  +: NUM_LINES] = senseQ;
    rdData[FLD_STATUS*FIELD_W +: NUM_LINES] = statusQ;
    rdData[FLD_CLEAR*FIELD_W  +: NUM_LINES] = clearRd;
    rdData[FLD_MASK*FIELD_W   +: NUM_LINES] = maskQ;
    rdData[FLD_BOTH*FIELD_W   +: NUM_LINES] = bothQ;
    rdData[FLD_LEVEL*FIELD_W  +: NUM_LINES] = levelQ;
  end
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk
  import ext_irq_pkg::*;
#(
  parameter int NUM_LINES  = 4,
  parameter int FIELD_W    = 4,
  parameter bit HELD_CLEAR = 1'b0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wrEn,
  input logic [31:0]          wrData,
  input logic [31:0]          rdData,
  input logic [NUM_LINES-1:0] irqOut
);
  logic [NUM_LINES-1:0] rdStat, rdClr, rdMask, wrClr;
  logic [4*NUM_LINES-1:0] rdCfg, wrCfg;
  logic unusedChk;

  assign rdStat = rdData[FLD_STATUS*FIELD_W +: NUM_LINES];
  assign rdClr  = rdData[FLD_CLEAR*FIELD_W  +: NUM_LINES];
  assign rdMask = rdData[FLD_MASK*FIELD_W   +: NUM_LINES];
  assign wrClr  = wrData[FLD_CLEAR*FIELD_W  +: NUM_LINES];
  assign rdCfg  = {rdData[FLD_SENSE*FIELD_W +: NUM_LINES], rdMask,
                   rdData[FLD_BOTH*FIELD_W +: NUM_LINES],
                   rdData[FLD_LEVEL*FIELD_W +: NUM_LINES]};
  assign wrCfg  = {wrData[FLD_SENSE*FIELD_W +: NUM_LINES],
                   wrData[FLD_MASK*FIELD_W +: NUM_LINES],
                   wrData[FLD_BOTH*FIELD_W +: NUM_LINES],
                   wrData[FLD_LEVEL*FIELD_W +: NUM_LINES]};
  assign unusedChk = ^{wrData, rdData};

  // R8
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irqOut & ~$past(rdMask)) == '0));

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |=> $stable(rdCfg));

  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> (rdCfg == $past(wrCfg)));

  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> ((rdStat & $past(wrClr)) == '0));

  generate
    if (HELD_CLEAR) begin : g_heldChk
      // R10
      held_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrEn && rdClr != '0) |=> ((rdStat & $past(rdClr)) == '0));
    end else begin : g_pulseChk
      // R9
      pulse_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrEn |=> (rdClr == '0));
    end
  endgenerate
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(
  .NUM_LINES(NUM_LINES), .FIELD_W(FIELD_W), .HELD_CLEAR(HELD_CLEAR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData),
  .rdData(rdData), .irqOut(irqOut)
);

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;
  localparam int NL = 4;
  localparam int FW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [NL-1:0] pins = '0;
  logic [31:0] rdA, rdB;
  logic [NL-1:0] outA, outB;

  always #4 clk = ~clk;

  ext_irq_ctrl #(.NUM_LINES(NL), .FIELD_W(FW), .HELD_CLEAR(1'b0)) u_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irqPins(pins), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdA), .irqOut(outA));

  ext_irq_ctrl #(.NUM_LINES(NL), .FIELD_W(FW), .HELD_CLEAR(1'b1)) u_heldDut (
    .clk(clk), .rst_n(rst_n), .irqPins(pins), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdB), .irqOut(outB));

  int vecCount = 0;
  int failCount = 0;
  string curReq = "R1";

  // reference state: index 0 pulse-clear build, index 1 held-clear build
  logic [NL-1:0] mS1[2], mS2[2], mS3[2], mSt[2], mOut[2];
  logic [NL-1:0] mSense[2], mMask[2], mBoth[2], mLvl[2], mClr[2];

  function automatic logic [31:0] fld(int f, logic [NL-1:0] bits);
    return 32'(bits) << (f * FW);
  endfunction

  function automatic logic [31:0] expRd(int k);
    return fld(0, mSense[k]) | fld(1, mSt[k]) | fld(2, mClr[k]) |
           fld(3, mMask[k]) | fld(4, mBoth[k]) | fld(5, mLvl[k]);
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      logic [NL-1:0] clrAct, nst;
      logic hit;
      if (!rst_n) begin
        mS1[k] = '0; mS2[k] = '0; mS3[k] = '0; mSt[k] = '0; mOut[k] = '0;
        mSense[k] = '0; mMask[k] = '0; mBoth[k] = '0; mLvl[k] = '0; mClr[k] = '0;
      end else begin
        clrAct = wrEn ? wrData[2*FW +: NL] : ((k == 1) ? mClr[k] : '0);
        for (int n = 0; n < NL; n++) begin
          if (mLvl[k][n])        hit = (mS2[k][n] == mSense[k][n]);
          else if (mBoth[k][n])  hit = mS2[k][n] ^ mS3[k][n];
          else if (mSense[k][n]) hit = mS2[k][n] & ~mS3[k][n];
          else                   hit = ~mS2[k][n] & mS3[k][n];
          if (clrAct[n])         nst[n] = 1'b0;
          else if (mLvl[k][n])   nst[n] = hit;
          else                   nst[n] = mSt[k][n] | hit;
        end
        mOut[k] = mSt[k] & mMask[k];
        mSt[k]  = nst;
        mS3[k]  = mS2[k];
        mS2[k]  = mS1[k];
        mS1[k]  = pins;
        if (wrEn) begin
          mSense[k] = wrData[0*FW +: NL];
          mMask[k]  = wrData[3*FW +: NL];
          mBoth[k]  = wrData[4*FW +: NL];
          mLvl[k]   = wrData[5*FW +: NL];
          if (k == 1) mClr[k] = wrData[2*FW +: NL];
        end
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // advance one cycle, then compare both builds against the reference
  task automatic step(int cycles = 1);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk(curReq, "irqOut pulse build", 32'(outA), 32'(mOut[0]));
      chk(curReq, "rdData pulse build", rdA, expRd(0));
      chk(curReq, "irqOut held build", 32'(outB), 32'(mOut[1]));
      chk(curReq, "rdData held build", rdB, expRd(1));
    end
  endtask

  task automatic wr(logic [31:0] d);
    wrEn = 1'b1; wrData = d;
    step(1);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] cfg;
    void'($urandom(32'd20210224));
    // R1: reset state
    step(3);
    @(negedge clk); rst_n = 1'b1;
    step(1);
    chk("R1", "reset rdData", rdA, 32'h0);
    chk("R1", "reset irqOut", 32'(outA), 32'h0);

    // R2 and R11: field readback, status write ignored, upper bits zero
    curReq = "R2";
    wr(fld(0, 4'b1010) | fld(1, 4'b1111) | fld(3, 4'b0101) |
       fld(4, 4'b0011) | fld(5, 4'b1100) | 32'hFF00_0000);
    chk("R2", "field readback", rdA,
        fld(0, 4'b1010) | fld(3, 4'b0101) | fld(4, 4'b0011) | fld(5, 4'b1100));
    chk("R11", "status write ignored", rdA[1*FW +: NL], 32'h0);
    wr(32'h0);
    step(4);

    // R4: rising edge on line 0, latency and latch
    curReq = "R4";
    cfg = fld(0, 4'b0001) | fld(3, 4'b0001);
    wr(cfg);
    pins[0] = 1'b1;
    step(3);
    chk("R8", "one cycle before due", 32'(outA[0]), 32'h0);
    step(1);
    chk("R4", "rising edge output", 32'(outA[0]), 32'h1);
    curReq = "R7";
    pins[0] = 1'b0;
    step(5);
    chk("R7", "edge status held", 32'(outA[0]), 32'h1);

    // R9 / R10: clear in both builds
    curReq = "R9";
    wr(cfg | fld(2, 4'b0001));
    step(1);
    chk("R9", "pulse clear drops output", 32'(outA[0]), 32'h0);
    chk("R9", "pulse clear reads zero", rdA[2*FW +: NL], 32'h0);
    chk("R10", "held clear reads one", rdB[2*FW +: NL], 32'h1);
    curReq = "R10";
    pins[0] = 1'b1;
    step(6);
    chk("R10", "held clear suppresses", 32'(outB[0]), 32'h0);
    chk("R4", "pulse build retriggers", 32'(outA[0]), 32'h1);
    wr(cfg);
    step(4);
    pins[0] = 1'b0;
    wr(fld(2, 4'b0001));

    // R5: falling edge on line 1
    curReq = "R5";
    cfg = fld(3, 4'b0010);
    wr(cfg);
    pins[1] = 1'b1;
    step(6);
    chk("R5", "no trigger on rise", 32'(outA[1]), 32'h0);
    pins[1] = 1'b0;
    step(4);
    chk("R5", "falling edge output", 32'(outA[1]), 32'h1);
    wr(fld(2, 4'b0010));

    // R6: any edge on line 2 with polarity bit set
    curReq = "R6";
    cfg = fld(0, 4'b0100) | fld(3, 4'b0100) | fld(4, 4'b0100);
    wr(cfg);
    pins[2] = 1'b1;
    step(4);
    chk("R6", "rise in any-edge mode", 32'(outA[2]), 32'h1);
    wr(cfg | fld(2, 4'b0100));
    step(2);
    pins[2] = 1'b0;
    step(4);
    chk("R6", "fall in any-edge mode", 32'(outA[2]), 32'h1);
    wr(fld(2, 4'b0100));

    // R3: level-high then level-low on line 3
    curReq = "R3";
    wr(fld(0, 4'b1000) | fld(3, 4'b1000) | fld(5, 4'b1000));
    pins[3] = 1'b1;
    step(4);
    chk("R3", "level high asserted", 32'(outA[3]), 32'h1);
    pins[3] = 1'b0;
    step(4);
    chk("R3", "level high released", 32'(outA[3]), 32'h0);
    wr(fld(3, 4'b1000) | fld(5, 4'b1000));
    step(3);
    chk("R3", "level low asserted", 32'(outA[3]), 32'h1);

    // mixed random traffic covers R8, R9 collisions and all modes
    curReq = "R8";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0) pins = pins ^ NL'($urandom());
      if ($urandom_range(0, 7) == 0) begin
        wrEn = 1'b1;
        wrData = $urandom() & ~(($urandom_range(0, 1) == 0) ? fld(2, '1) : 32'h0);
      end else begin
        wrEn = 1'b0; wrData = '0;
      end
      step(1);
    end
    wrEn = 1'b0;
    summary();
    $finish;
  end
endmodule